// File: doc/BRIEF.md
# GPIO Port Register Controller

This block is the register front end and pad control for one 16-pin general-purpose I/O port. Software reaches it over a plain 32-bit register bus: an address, a write strobe, write data and combinational read data. It keeps every pin's configuration (operating mode, driver type, edge speed, pull bias and alternate function number), an output data latch, and a write-only word that sets or clears single latch bits with no read-modify-write. It also brings the pin levels in through a two-stage synchronizer so software can read them.

For every pin the block works out the pad controls: output enable, output value, open-drain select, pull-up, pull-down and a two-bit speed code. In alternate mode the pin's output comes from one of sixteen peripheral outputs, picked by that pin's four-bit function number. The analog pad path, any lock sequence and interrupt logic sit outside this block.

Top module: `pinport_ctrl`

## Requirements
- R1: After reset every configuration word, the output latch and both function words read 0. All pad output enables, pulls and speed codes are 0.
- R2: The word offsets are mode 0x00, driver type 0x04, speed 0x08, pull 0x0C, input 0x10, output latch 0x14, set/clear 0x18, lock 0x1C, function-low 0x20 and function-high 0x24. Pin n uses bits [2n+1:2n] of the mode, speed and pull words and bit n of the driver-type word. Written values read back, and bits 31:16 of the driver-type word read 0.
- R3: A write to the output latch word stores bits 15:0. Bits 31:16 are dropped and read back as 0.
- R4: A write to the set/clear word with bit n = 1 sets latch bit n, and with bit n+16 = 1 clears it. A latch bit whose set bit and clear bit are both 0 keeps its value.
- R5: If the set bit and the clear bit of the same pin are both 1 in one write, the latch bit becomes 1.
- R6: The set/clear and lock words read 0. Writes to the lock word and the input word change no state.
- R7: A pin level that is present before clock edge k shows in the input word after edge k+1, and not after edge k.
- R8: A pin whose mode is 3 (analog) reads 0 in the input word, whatever its pin level.
- R9: The output enable of a pin is 1 only in mode 1 (output) or mode 2 (alternate). In mode 1 the pad value equals the latch bit. In modes 0 (input) and 3 the enable is 0.
- R10: Driver-type bit 1 selects open-drain: the pad is enabled only while its value is 0, and the open-drain control equals the driver-type bit. Driver-type bit 0 selects push-pull.
- R11: In mode 2, pin n takes function number f from the function-low word (pins 0-7) or the function-high word (pins 8-15), bits [4(n mod 8)+3 : 4(n mod 8)]. Its pad value is alternate input bit 16n+f.
- R12: Pull code 1 drives pull-up only and code 2 drives pull-down only. Codes 0 and 3 drive neither. The speed code of pin n reaches bits [2n+1:2n] of the speed output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | Pin levels from the pads |
| alt_in | input | 256 | Peripheral outputs, 16 per pin, pin n at bits [16n+15:16n] |
| pad_oe | output | 16 | Pad output enable |
| pad_out | output | 16 | Pad output value |
| pad_od | output | 16 | Open-drain select |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |
| pad_speed | output | 32 | Speed code, two bits per pin |

## Verification
Two latch-updating actions can land in the same access: the set request and the clear request for one pin inside a single set/clear write. The bench makes this happen by writing words where both halves carry ones for the same pin, on a latch bit that was 0 and on one that was 1, and then a word with all 32 bits set. It judges the outcome by reading back the output latch word: the set must win in every case, and pins named in neither half must keep their old values.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

  // Byte offsets of the register words; software depends on these.
  localparam int unsigned OFS_MODE  = 32'h00;
  localparam int unsigned OFS_OTYPE = 32'h04;
  localparam int unsigned OFS_SPEED = 32'h08;
  localparam int unsigned OFS_PULL  = 32'h0C;
  localparam int unsigned OFS_IN    = 32'h10;
  localparam int unsigned OFS_OUT   = 32'h14;
  localparam int unsigned OFS_SETCLR = 32'h18;
  localparam int unsigned OFS_LOCK  = 32'h1C;
  localparam int unsigned OFS_FNLO  = 32'h20;
  localparam int unsigned OFS_FNHI  = 32'h24;

  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    PM_IN  = 2'd0,
    PM_GPO = 2'd1,
    PM_ALT = 2'd2,
    PM_ANA = 2'd3
  } pin_mode_e;

  typedef enum logic [1:0] {
    PB_NONE = 2'd0,
    PB_UP   = 2'd1,
    PB_DOWN = 2'd2,
    PB_RSVD = 2'd3
  } pin_bias_e;

endpackage

// File: rtl/pinport_regfile.sv
module pinport_regfile
  import pinport_pkg::*;
#(
  parameter int N      = 16,
  parameter int NFUNC  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int AF_W  = $clog2(NFUNC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [N-1:0]        idr_val,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [2*N-1:0]      mode_q,
  output logic [N-1:0]        otype_q,
  output logic [2*N-1:0]      speed_q,
  output logic [2*N-1:0]      pull_q,
  output logic [N-1:0]        odr_q,
  output logic [N*AF_W-1:0]   afsel_q
);

  localparam int WORD_W  = ADDR_W - 2;
  localparam int CLR_LSB = DATA_W / 2;

  logic [WORD_W-1:0] word;
  logic              unused_addr_lsbs;
  assign word             = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsbs = ^bus_addr[1:0];

  function automatic logic is_word(input logic [WORD_W-1:0] w, input int unsigned ofs);
    return w == WORD_W'(ofs >> 2);
  endfunction

  logic hit_mode, hit_otype, hit_speed, hit_pull, hit_out, hit_setclr, hit_fnlo, hit_fnhi;
  logic [DATA_W-1:0] fnlo_q, fnhi_q;
  logic [2*DATA_W-1:0] fn_all;

  logic [2*N-1:0]    mode_d, speed_d, pull_d;
  logic [N-1:0]      otype_d, odr_d;
  logic [DATA_W-1:0] fnlo_d, fnhi_d;
  logic              odr_en;

  // Next-state logic
  always_comb begin
    hit_mode   = bus_we && is_word(word, OFS_MODE);
    hit_otype  = bus_we && is_word(word, OFS_OTYPE);
    hit_speed  = bus_we && is_word(word, OFS_SPEED);
    hit_pull   = bus_we && is_word(word, OFS_PULL);
    hit_out    = bus_we && is_word(word, OFS_OUT);
    hit_setclr = bus_we && is_word(word, OFS_SETCLR);
    hit_fnlo   = bus_we && is_word(word, OFS_FNLO);
    hit_fnhi   = bus_we && is_word(word, OFS_FNHI);

    mode_d  = bus_wdata[2*N-1:0];
    speed_d = bus_wdata[2*N-1:0];
    pull_d  = bus_wdata[2*N-1:0];
    otype_d = bus_wdata[N-1:0];
    fnlo_d  = bus_wdata;
    fnhi_d  = bus_wdata;

    odr_en = hit_out || hit_setclr;
    if (hit_out) begin
      odr_d = bus_wdata[N-1:0];
    end else begin
      // clear first, then set, so a set request wins
      odr_d = (odr_q & ~bus_wdata[CLR_LSB +: N]) | bus_wdata[N-1:0];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      odr_q   <= '0;
      fnlo_q  <= '0;
      fnhi_q  <= '0;
    end else begin
      if (hit_mode)  mode_q  <= mode_d;
      if (hit_otype) otype_q <= otype_d;
      if (hit_speed) speed_q <= speed_d;
      if (hit_pull)  pull_q  <= pull_d;
      if (odr_en)    odr_q   <= odr_d;
      if (hit_fnlo)  fnlo_q  <= fnlo_d;
      if (hit_fnhi)  fnhi_q  <= fnhi_d;
    end
  end

  assign fn_all  = {fnhi_q, fnlo_q};
  assign afsel_q = fn_all[N*AF_W-1:0];

  // Read-back
  always_comb begin
    bus_rdata = '0;
    if (is_word(word, OFS_MODE))       bus_rdata = DATA_W'(mode_q);
    else if (is_word(word, OFS_OTYPE)) bus_rdata = DATA_W'(otype_q);
    else if (is_word(word, OFS_SPEED)) bus_rdata = DATA_W'(speed_q);
    else if (is_word(word, OFS_PULL))  bus_rdata = DATA_W'(pull_q);
    else if (is_word(word, OFS_IN))    bus_rdata = DATA_W'(idr_val);
    else if (is_word(word, OFS_OUT))   bus_rdata = DATA_W'(odr_q);
    else if (is_word(word, OFS_FNLO))  bus_rdata = fnlo_q;
    else if (is_word(word, OFS_FNHI))  bus_rdata = fnhi_q;
  end

  // Set bits are 1 in the latch after a set/clear write
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_setclr |=> ((odr_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

  // Clear-only bits are 0 after a set/clear write
  assert_clear_applies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_setclr |=> ((odr_q & $past(bus_wdata[CLR_LSB +: N] & ~bus_wdata[N-1:0])) == '0));

  // Bits named in neither half keep their value
  assert_untouched_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_setclr |=> (((odr_q ^ $past(odr_q)) &
                     ~$past(bus_wdata[CLR_LSB +: N] | bus_wdata[N-1:0])) == '0));

  // Write-only and lock words read as zero
  assert_setclr_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_word(word, OFS_SETCLR) || is_word(word, OFS_LOCK)) |-> (bus_rdata == '0));

endmodule

// File: rtl/pinport_insync.sv
module pinport_insync
  import pinport_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] analog_mask,
  output logic [N-1:0] idr_val
);

  logic [N-1:0] sync_q [SYNC_DEPTH];
  logic [N-1:0] sync_d [SYNC_DEPTH];

  always_comb begin
    sync_d[0] = pin_in;
    for (int s = 1; s < SYNC_DEPTH; s++) sync_d[s] = sync_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_DEPTH; s++) sync_q[s] <= '0;
    end else begin
      for (int s = 0; s < SYNC_DEPTH; s++) sync_q[s] <= sync_d[s];
    end
  end

  assign idr_val = sync_q[SYNC_DEPTH-1] & ~analog_mask;

  // Cycles since reset, saturating, so the latency check never reaches before reset
  logic [1:0] settle_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               settle_q <= '0;
    else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
  end

  assert_input_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == 2'd2) |-> (((idr_val ^ $past(pin_in, 2)) & ~analog_mask) == '0));

endmodule

// File: rtl/pinport_pad.sv
module pinport_pad
  import pinport_pkg::*;
#(
  parameter int N     = 16,
  parameter int NFUNC = 16,
  localparam int AF_W = $clog2(NFUNC)
) (
  input  logic [2*N-1:0]     mode_q,
  input  logic [N-1:0]       otype_q,
  input  logic [N-1:0]       odr_q,
  input  logic [2*N-1:0]     pull_q,
  input  logic [N*AF_W-1:0]  afsel_q,
  input  logic [N*NFUNC-1:0] alt_in,
  output logic [N-1:0]       pad_oe,
  output logic [N-1:0]       pad_out,
  output logic [N-1:0]       pad_od,
  output logic [N-1:0]       pad_pu,
  output logic [N-1:0]       pad_pd
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    pin_mode_e        mode;
    pin_bias_e        bias;
    logic [AF_W-1:0]  fsel;
    logic [NFUNC-1:0] fvec;
    logic             val;
    logic             drive;

    assign mode = pin_mode_e'(mode_q[2*g +: 2]);
    assign bias = pin_bias_e'(pull_q[2*g +: 2]);
    assign fsel = afsel_q[g*AF_W +: AF_W];
    assign fvec = alt_in[g*NFUNC +: NFUNC];

    always_comb begin
      val   = 1'b0;
      drive = 1'b0;
      case (mode)
        PM_GPO: begin val = odr_q[g];  drive = 1'b1; end
        PM_ALT: begin val = fvec[fsel]; drive = 1'b1; end
        default: begin val = 1'b0;     drive = 1'b0; end
      endcase
    end

    assign pad_out[g] = val;
    assign pad_oe[g]  = drive && (!otype_q[g] || !val);
    assign pad_od[g]  = otype_q[g];
    assign pad_pu[g]  = (bias == PB_UP);
    assign pad_pd[g]  = (bias == PB_DOWN);
  end

endmodule

// File: rtl/pinport_ctrl.sv
module pinport_ctrl
  import pinport_pkg::*;
#(
  parameter int N      = 16,
  parameter int NFUNC  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [N-1:0]         pin_in,
  input  logic [N*NFUNC-1:0]   alt_in,
  output logic [N-1:0]         pad_oe,
  output logic [N-1:0]         pad_out,
  output logic [N-1:0]         pad_od,
  output logic [N-1:0]         pad_pu,
  output logic [N-1:0]         pad_pd,
  output logic [2*N-1:0]       pad_speed
);

  localparam int AF_W = $clog2(NFUNC);

  logic [2*N-1:0]    mode_q, speed_q, pull_q;
  logic [N-1:0]      otype_q, odr_q, idr_val;
  logic [N*AF_W-1:0] afsel_q;
  logic [N-1:0]      analog_mask, drive_mask;

  always_comb begin
    for (int p = 0; p < N; p++) begin
      analog_mask[p] = (mode_q[2*p +: 2] == PM_ANA);
      drive_mask[p]  = (mode_q[2*p +: 2] == PM_GPO) || (mode_q[2*p +: 2] == PM_ALT);
    end
  end

  pinport_regfile #(.N(N), .NFUNC(NFUNC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .idr_val   (idr_val),
    .bus_rdata (bus_rdata),
    .mode_q    (mode_q),
    .otype_q   (otype_q),
    .speed_q   (speed_q),
    .pull_q    (pull_q),
    .odr_q     (odr_q),
    .afsel_q   (afsel_q)
  );

  pinport_insync #(.N(N)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_in      (pin_in),
    .analog_mask (analog_mask),
    .idr_val     (idr_val)
  );

  pinport_pad #(.N(N), .NFUNC(NFUNC)) u_pad (
    .mode_q  (mode_q),
    .otype_q (otype_q),
    .odr_q   (odr_q),
    .pull_q  (pull_q),
    .afsel_q (afsel_q),
    .alt_in  (alt_in),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .pad_od  (pad_od),
    .pad_pu  (pad_pu),
    .pad_pd  (pad_pd)
  );

  assign pad_speed = speed_q;

  // Pads are enabled only in output or alternate mode
  assert_oe_only_driving_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~drive_mask) == '0);

  // An open-drain pad never drives a high level
  assert_od_never_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_od & pad_out) == '0);

  // Analog pins read zero in the input word
  assert_analog_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idr_val & analog_mask) == '0);

  for (genvar g = 0; g < N; g++) begin : g_chk
    // Alternate pins follow the peripheral output picked by their function number
    assert_alt_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*g +: 2] == PM_ALT) |->
        (pad_out[g] == alt_in[g*NFUNC + int'(afsel_q[g*AF_W +: AF_W])]));
    // Output mode reflects the latch bit
    assert_gpo_follows_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*g +: 2] == PM_GPO) |-> (pad_out[g] == odr_q[g]));
  end

endmodule

// File: tb/pinport_ctrl_tb.sv
module pinport_ctrl_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [7:0]   bus_addr;
  logic         bus_we;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [15:0]  pin_in;
  logic [255:0] alt_in;
  logic [15:0]  pad_oe, pad_out, pad_od, pad_pu, pad_pd;
  logic [31:0]  pad_speed;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  always #4 clk = ~clk;

  pinport_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .alt_in    (alt_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_od    (pad_od),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .pad_speed (pad_speed)
  );

  localparam logic [7:0] A_MODE = 8'h00, A_OTYPE = 8'h04, A_SPEED = 8'h08, A_PULL = 8'h0C,
                         A_IN = 8'h10, A_OUT = 8'h14, A_SC = 8'h18, A_LOCK = 8'h1C,
                         A_FNLO = 8'h20, A_FNHI = 8'h24;

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] re;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{A_OUT,   32'h0000_A5A5, A_OUT,   32'h0000_A5A5, 4'd3},  // R3 latch write
    '{A_SC,    32'h0000_0002, A_OUT,   32'h0000_A5A7, 4'd4},  // R4 set bit 1
    '{A_SC,    32'h0001_0000, A_OUT,   32'h0000_A5A6, 4'd4},  // R4 clear bit 0
    '{A_SC,    32'h0008_0008, A_OUT,   32'h0000_A5AE, 4'd5},  // R5 both on a 0 bit
    '{A_SC,    32'h0004_0004, A_OUT,   32'h0000_A5AE, 4'd5},  // R5 both on a 1 bit
    '{A_SC,    32'hFFFF_0000, A_OUT,   32'h0000_0000, 4'd4},  // R4 clear all
    '{A_SC,    32'h0000_0000, A_SC,    32'h0000_0000, 4'd6},  // R6 set/clear reads 0
    '{A_MODE,  32'h1234_5678, A_MODE,  32'h1234_5678, 4'd2},  // R2
    '{A_OTYPE, 32'hFFFF_FFFF, A_OTYPE, 32'h0000_FFFF, 4'd2},  // R2 upper half 0
    '{A_SPEED, 32'hDEAD_BEEF, A_SPEED, 32'hDEAD_BEEF, 4'd2},  // R2
    '{A_PULL,  32'h0F0F_0F0F, A_PULL,  32'h0F0F_0F0F, 4'd2},  // R2
    '{A_FNLO,  32'h7654_3210, A_FNLO,  32'h7654_3210, 4'd2},  // R2
    '{A_FNHI,  32'hFEDC_BA98, A_FNHI,  32'hFEDC_BA98, 4'd2},  // R2
    '{A_LOCK,  32'hFFFF_FFFF, A_LOCK,  32'h0000_0000, 4'd6},  // R6 lock inert
    '{A_OUT,   32'hFFFF_1234, A_OUT,   32'h0000_1234, 4'd3}   // R3 upper bits dropped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] r;
    logic [31:0] fnlo, fnhi;
    logic [3:0]  fsel;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    pin_in = '0; alt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_MODE, r);  check("R1 mode", r, 0);
    rd(A_OTYPE, r); check("R1 otype", r, 0);
    rd(A_SPEED, r); check("R1 speed", r, 0);
    rd(A_PULL, r);  check("R1 pull", r, 0);
    rd(A_OUT, r);   check("R1 latch", r, 0);
    rd(A_FNLO, r);  check("R1 fnlo", r, 0);
    rd(A_FNHI, r);  check("R1 fnhi", r, 0);
    check("R1 pad_oe", {16'h0, pad_oe}, 0);
    check("R1 pulls", {pad_pu, pad_pd}, 0);
    check("R1 pad_speed", pad_speed, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd(VEC[i].ra, r);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), r, VEC[i].re);
    end
    rd(A_IN, r); check("R6 input word untouched", r, 0);

    // restore
    wr(A_MODE, 0); wr(A_OTYPE, 0); wr(A_SPEED, 0); wr(A_PULL, 0);
    wr(A_FNLO, 0); wr(A_FNHI, 0); wr(A_OUT, 0);

    // R5 all set and clear bits at once
    wr(A_SC, 32'hFFFF_FFFF);
    rd(A_OUT, r); check("R5 all both", r, 32'h0000_FFFF);
    wr(A_OUT, 0);

    // R7 synchronizer latency
    bus_addr = A_IN;
    @(negedge clk);
    pin_in = 16'hA5C3;
    @(negedge clk);
    rd(A_IN, r); check("R7 one edge", r, 0);
    @(negedge clk);
    rd(A_IN, r); check("R7 two edges", r, 32'h0000_A5C3);

    // R8 analog pin reads 0
    wr(A_MODE, 32'h0000_0003);
    rd(A_IN, r); check("R8 analog pin0", r, 32'h0000_A5C2);
    check("R9 analog no oe", {16'h0, pad_oe}, 0);

    // R9 output mode
    wr(A_OUT, 32'h0000_00F0);
    wr(A_MODE, 32'h5555_5555);
    check("R9 oe gpo", {16'h0, pad_oe}, 32'h0000_FFFF);
    check("R9 out gpo", {16'h0, pad_out}, 32'h0000_00F0);

    // R10 open drain
    wr(A_OTYPE, 32'h0000_000F);
    wr(A_OUT, 32'h0000_0005);
    check("R10 oe od", {16'h0, pad_oe}, 32'h0000_FFFA);
    check("R10 od ctl", {16'h0, pad_od}, 32'h0000_000F);
    wr(A_MODE, 0);
    check("R9 input no oe", {16'h0, pad_oe}, 0);
    wr(A_OTYPE, 0);

    // R11 alternate selection
    fnlo = 32'h7654_3210;
    fnhi = 32'h89AB_CDEF;
    wr(A_FNLO, fnlo);
    wr(A_FNHI, fnhi);
    wr(A_MODE, 32'hAAAA_AAAA);
    for (int pass = 0; pass < 3; pass++) begin
      logic [15:0] exp;
      for (int n = 0; n < 16; n++) begin
        fsel = (n < 8) ? fnlo[4*(n%8) +: 4] : fnhi[4*(n%8) +: 4];
        for (int f = 0; f < 16; f++) begin
          logic hot;
          hot = (f == int'(fsel));
          case (pass)
            0: alt_in[16*n+f] = hot;
            1: alt_in[16*n+f] = ~hot;
            default: alt_in[16*n+f] = hot && (n % 2 == 0);
          endcase
        end
        exp[n] = (pass == 0) ? 1'b1 : (pass == 1) ? 1'b0 : (n % 2 == 0);
      end
      #1;
      check($sformatf("R11 pass %0d", pass), {16'h0, pad_out}, {16'h0, exp});
    end
    check("R11 oe alt", {16'h0, pad_oe}, 32'h0000_FFFF);
    wr(A_MODE, 0);

    // R12 pull and speed
    wr(A_PULL, 32'h0000_00E4);
    check("R12 pull-up", {16'h0, pad_pu}, 32'h0000_0002);
    check("R12 pull-down", {16'h0, pad_pd}, 32'h0000_0004);
    wr(A_SPEED, 32'h0000_001B);
    check("R12 speed", pad_speed, 32'h0000_001B);

    summary();
  end

endmodule